// File: doc/BRIEF.md
# DRAM Bank Read Transaction Sequencer

This block sits on the controller side of a packet-based DRAM. It drives one closed-page read transaction to a single bank. The order of commands is fixed: activate the row, issue one or more column reads, precharge the bank, and then wait until the bank can be activated again. A request carries a device, a bank, a row and a packed list of column addresses. The row channel carries the activate and precharge strobes. The column channel carries the read strobe. Each strobe comes with its own address fields.

Every minimum spacing is a parameter counted in clock cycles. These are activate-to-read, read-to-read, activate-to-precharge, last-read-to-precharge, activate-to-activate and precharge-to-activate. Each spacing has its own down-counter, and a command goes out in the first cycle in which all of its counters have expired. A separate strobe marks the cycle in which the read data of each read is due back, so that downstream capture logic can align to it.

Top module: `rd_txn_seq`

## Requirements
- R1: An activate strobe (`act_o`) appears in the cycle after a request is accepted, carrying the latched device, bank and row. Activate and precharge never share a cycle. Every address output is zero in any cycle in which its own strobe is low.
- R2: The first read strobe comes exactly T_RCD cycles after the activate. It carries the latched device and bank and the column taken from bits [COL_W-1:0] of the column list.
- R3: `req_nrd_i` holds the number of reads minus one, so 0 means a single read. Read i uses the column at bits [i*COL_W +: COL_W]. Reads are issued in ascending order of i, exactly T_CC cycles apart.
- R4: `data_exp_o` pulses for one cycle exactly T_CAC cycles after each read strobe, and is low at all other times.
- R5: The precharge strobe carries only device and bank, with the row field at zero. It comes exactly at the later of (activate + T_RAS) and (last read + T_RDP).
- R6: The next activate comes no earlier than the later of (previous activate + T_RC) and (precharge + T_RP). When a request is waiting, it comes exactly then.
- R7: `req_ready_o` is high only in the idle phase, and from the cycle before the next activate becomes legal. Request inputs presented while ready is low are ignored.
- R8: During reset and just after it, all strobes are low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_dev_i | input | DEV_W | Target device |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Row to open |
| req_nrd_i | input | IDX_W | Number of reads minus one |
| req_cols_i | input | MAX_RD*COL_W | Packed column list, entry i at [i*COL_W +: COL_W] |
| act_o | output | 1 | Activate strobe, row channel |
| pre_o | output | 1 | Precharge strobe, row channel |
| row_dev_o | output | DEV_W | Row channel device |
| row_bank_o | output | BANK_W | Row channel bank |
| row_addr_o | output | ROW_W | Row address, activate only |
| rd_o | output | 1 | Read strobe, column channel |
| col_dev_o | output | DEV_W | Column channel device |
| col_bank_o | output | BANK_W | Column channel bank |
| col_addr_o | output | COL_W | Column address |
| data_exp_o | output | 1 | Read data due this cycle |

## Verification
The bench sweeps every read count from one to the maximum, and chooses the spacings so that short transactions are bound by the activate-to-precharge limit and long ones by the last-read limit. A design that ignored the read-to-precharge counter would precharge too early on the four-read case. One that ignored activate-to-precharge would precharge too early on the single-read case. The next-activate check likewise switches between the two limits depending on read count, so dropping either counter shifts the handshake cycle. Request fields are scrambled while ready is low, which catches a design that samples them outside the handshake. A quiet gap with valid low confirms that the sequencer issues no command on its own.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_COL  = 2'd2,
    ST_PRE  = 2'd3
  } seq_state_e;

  localparam int TM_RCD = 0;
  localparam int TM_CC  = 1;
  localparam int TM_RAS = 2;
  localparam int TM_RDP = 3;
  localparam int TM_RC  = 4;
  localparam int TM_RP  = 5;
  localparam int NUM_TM = 6;
endpackage

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             zero_o,
  output logic             soon_o
);
  logic [CNT_W-1:0] cnt_q;

  // loaded with len-1 in the command cycle: reaches zero len cycles later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign soon_o = (cnt_q <= CNT_W'(1));

  p_timer_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !start_i) |=> zero_o);
endmodule

// File: rtl/pulse_delay.sv
module pulse_delay #(
  parameter int DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  logic [DLY-1:0] sr_q;

  generate
    if (DLY == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= in_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[DLY-2:0], in_i};
      end
    end
  endgenerate

  assign out_o = sr_q[DLY-1];
endmodule

// File: rtl/rd_txn_seq.sv
module rd_txn_seq
  import rts_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int BANK_W = 4,
  parameter int ROW_W  = 9,
  parameter int COL_W  = 6,
  parameter int MAX_RD = 4,   // power of two
  parameter int CNT_W  = 8,
  parameter int T_RCD  = 3,   // all spacings >= 1, T_RP >= 2
  parameter int T_CC   = 2,
  parameter int T_CAC  = 4,
  parameter int T_RAS  = 8,
  parameter int T_RDP  = 3,
  parameter int T_RC   = 12,
  parameter int T_RP   = 3,
  localparam int IDX_W = (MAX_RD > 1) ? $clog2(MAX_RD) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [DEV_W-1:0]        req_dev_i,
  input  logic [BANK_W-1:0]       req_bank_i,
  input  logic [ROW_W-1:0]        req_row_i,
  input  logic [IDX_W-1:0]        req_nrd_i,
  input  logic [MAX_RD*COL_W-1:0] req_cols_i,
  output logic                    act_o,
  output logic                    pre_o,
  output logic [DEV_W-1:0]        row_dev_o,
  output logic [BANK_W-1:0]       row_bank_o,
  output logic [ROW_W-1:0]        row_addr_o,
  output logic                    rd_o,
  output logic [DEV_W-1:0]        col_dev_o,
  output logic [BANK_W-1:0]       col_bank_o,
  output logic [COL_W-1:0]        col_addr_o,
  output logic                    data_exp_o
);
  seq_state_e               state_q, state_d;
  logic [DEV_W-1:0]         dev_q;
  logic [BANK_W-1:0]        bank_q;
  logic [ROW_W-1:0]         row_q;
  logic [IDX_W-1:0]         nrd_q;
  logic [MAX_RD*COL_W-1:0]  cols_q;
  logic [IDX_W-1:0]         idx_q;
  logic                     accept;
  logic                     last_rd;

  logic [NUM_TM-1:0]        tm_start, tm_zero, tm_soon;
  logic [CNT_W-1:0]         tm_len [NUM_TM];

  always_comb begin
    tm_len[TM_RCD] = CNT_W'(T_RCD);
    tm_len[TM_CC]  = CNT_W'(T_CC);
    tm_len[TM_RAS] = CNT_W'(T_RAS);
    tm_len[TM_RDP] = CNT_W'(T_RDP);
    tm_len[TM_RC]  = CNT_W'(T_RC);
    tm_len[TM_RP]  = CNT_W'(T_RP);
  end

  always_comb begin
    tm_start         = '0;
    tm_start[TM_RCD] = act_o;
    tm_start[TM_RAS] = act_o;
    tm_start[TM_RC]  = act_o;
    tm_start[TM_CC]  = rd_o;
    tm_start[TM_RDP] = rd_o;
    tm_start[TM_RP]  = pre_o;
  end

  generate
    for (genvar g = 0; g < NUM_TM; g++) begin : g_tm
      gap_timer #(.CNT_W(CNT_W)) u_tm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(tm_start[g]),
        .len_i  (tm_len[g]),
        .zero_o (tm_zero[g]),
        .soon_o (tm_soon[g])
      );
    end
  endgenerate

  // ready one cycle early: the activate follows the handshake edge
  assign req_ready_o = (state_q == ST_IDLE) && tm_soon[TM_RC] && tm_soon[TM_RP];
  assign accept      = req_valid_i && req_ready_o;
  assign act_o       = (state_q == ST_ACT);
  assign rd_o        = (state_q == ST_COL) && tm_zero[TM_RCD] && tm_zero[TM_CC];
  assign pre_o       = (state_q == ST_PRE) && tm_zero[TM_RAS] && tm_zero[TM_RDP];
  assign last_rd     = rd_o && (idx_q == nrd_q);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)  state_d = ST_ACT;
      ST_ACT:               state_d = ST_COL;
      ST_COL:  if (last_rd) state_d = ST_PRE;
      ST_PRE:  if (pre_o)   state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dev_q   <= '0;
      bank_q  <= '0;
      row_q   <= '0;
      nrd_q   <= '0;
      cols_q  <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        dev_q  <= req_dev_i;
        bank_q <= req_bank_i;
        row_q  <= req_row_i;
        nrd_q  <= req_nrd_i;
        cols_q <= req_cols_i;
        idx_q  <= '0;
      end else if (rd_o) begin
        idx_q  <= last_rd ? '0 : idx_q + 1'b1;
      end
    end
  end

  assign row_dev_o  = (act_o || pre_o) ? dev_q  : '0;
  assign row_bank_o = (act_o || pre_o) ? bank_q : '0;
  assign row_addr_o = act_o ? row_q : '0;
  assign col_dev_o  = rd_o ? dev_q  : '0;
  assign col_bank_o = rd_o ? bank_q : '0;
  assign col_addr_o = rd_o ? cols_q[idx_q*COL_W +: COL_W] : '0;

  pulse_delay #(.DLY(T_CAC)) u_cac (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (rd_o),
    .out_o (data_exp_o)
  );

  p_row_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act_o && pre_o));

  p_rd_closed_after_pre_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_o |=> !rd_o);

  p_act_windows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |-> (tm_zero[TM_RC] && tm_zero[TM_RP]));

  p_busy_no_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o || rd_o || pre_o) |-> !req_ready_o);
endmodule

// File: tb/rd_txn_seq_test.sv
module rd_txn_seq_test;
  localparam int DEV_W = 5, BANK_W = 4, ROW_W = 9, COL_W = 6, MAX_RD = 4, IDX_W = 2;
  localparam int T_RCD = 3, T_CC = 2, T_CAC = 4, T_RAS = 8, T_RDP = 3, T_RC = 12, T_RP = 3;
  localparam int NC = 1024, NTX = 7;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [DEV_W-1:0] req_dev_i = '0;
  logic [BANK_W-1:0] req_bank_i = '0;
  logic [ROW_W-1:0] req_row_i = '0;
  logic [IDX_W-1:0] req_nrd_i = '0;
  logic [MAX_RD*COL_W-1:0] req_cols_i = '0;
  logic act_o, pre_o, rd_o, data_exp_o;
  logic [DEV_W-1:0] row_dev_o, col_dev_o;
  logic [BANK_W-1:0] row_bank_o, col_bank_o;
  logic [ROW_W-1:0] row_addr_o;
  logic [COL_W-1:0] col_addr_o;

  rd_txn_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_dev_i(req_dev_i), .req_bank_i(req_bank_i), .req_row_i(req_row_i),
    .req_nrd_i(req_nrd_i), .req_cols_i(req_cols_i), .act_o(act_o), .pre_o(pre_o),
    .row_dev_o(row_dev_o), .row_bank_o(row_bank_o), .row_addr_o(row_addr_o),
    .rd_o(rd_o), .col_dev_o(col_dev_o), .col_bank_o(col_bank_o),
    .col_addr_o(col_addr_o), .data_exp_o(data_exp_o)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  bit e_act[NC], e_pre[NC], e_rd[NC], e_dat[NC];
  int e_tx[NC], e_col[NC];
  int t_dev[NTX], t_bank[NTX], t_row[NTX], t_n[NTX], t_col[NTX][MAX_RD];
  int next_a = 0, last_end = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // expected schedule from the requirements
  task automatic schedule(int k, int a);
    int r = 0, p;
    e_act[a] = 1; e_tx[a] = k;
    for (int i = 0; i < t_n[k]; i++) begin
      r = a + T_RCD + i * T_CC;
      e_rd[r] = 1; e_tx[r] = k; e_col[r] = t_col[k][i];
      e_dat[r + T_CAC] = 1;
    end
    p = imax(a + T_RAS, r + T_RDP);
    e_pre[p] = 1; e_tx[p] = k;
    next_a = imax(a + T_RC, p + T_RP);
    last_end = imax(p + T_RP, r + T_CAC) + 4;
  endtask

  // per-cycle output monitor
  always @(negedge clk) begin
    if (rst_ni && !done && cyc < NC) begin
      int k;
      k = e_tx[cyc];
      chk("R1 act", act_o, e_act[cyc]);
      chk("R5 pre", pre_o, e_pre[cyc]);
      chk("R3 rd", rd_o, e_rd[cyc]);
      chk("R4 data_exp", data_exp_o, e_dat[cyc]);
      if (e_act[cyc] || e_pre[cyc]) begin
        chk("R1 row_dev", row_dev_o, t_dev[k]);
        chk("R1 row_bank", row_bank_o, t_bank[k]);
        chk(e_act[cyc] ? "R1 row_addr" : "R5 row_addr", row_addr_o, e_act[cyc] ? t_row[k] : 0);
      end else begin
        chk("R1 row idle", {row_dev_o, row_bank_o, row_addr_o}, 0);
      end
      if (e_rd[cyc]) begin
        chk("R2 col_dev", col_dev_o, t_dev[k]);
        chk("R2 col_bank", col_bank_o, t_bank[k]);
        chk("R3 col_addr", col_addr_o, e_col[cyc]);
      end else begin
        chk("R1 col idle", {col_dev_o, col_bank_o, col_addr_o}, 0);
      end
    end
  end

  task automatic drive_txn(int k);
    for (int i = 0; i < MAX_RD; i++) req_cols_i[i*COL_W +: COL_W] = COL_W'(t_col[k][i]);
    req_dev_i = DEV_W'(t_dev[k]); req_bank_i = BANK_W'(t_bank[k]);
    req_row_i = ROW_W'(t_row[k]); req_nrd_i = IDX_W'(t_n[k] - 1);
  endtask

  task automatic drive_junk();
    req_dev_i = DEV_W'(cyc * 7 + 3); req_bank_i = BANK_W'(cyc + 9);
    req_row_i = ROW_W'(cyc * 31 + 5); req_nrd_i = IDX_W'(cyc);
    req_cols_i = {4{COL_W'(cyc * 13 + 1)}};
  endtask

  task automatic run_txn(int k);
    int hs, exp_hs;
    req_valid_i = 1'b1;
    exp_hs = imax(cyc, next_a - 1);
    forever begin
      if (req_ready_o) begin
        drive_txn(k);
        hs = cyc;
        break;
      end
      drive_junk();   // R7: ignored while ready is low
      @(negedge clk);
    end
    chk("R6 R7 handshake cycle", hs, exp_hs);
    @(posedge clk);
    schedule(k, hs + 1);
    @(negedge clk);
    drive_junk();
  endtask

  initial begin
    for (int k = 0; k < NTX; k++) begin
      t_dev[k] = (k * 3 + 1) % 32; t_bank[k] = (k * 5 + 2) % 16;
      t_row[k] = (k * 71 + 17) % 512;
      t_n[k] = (k < 4) ? k + 1 : ((k == 4) ? 4 : ((k == 5) ? 1 : 2));
      for (int i = 0; i < MAX_RD; i++) t_col[k][i] = (k * 7 + i * 5 + 1) % 64;
    end
    repeat (3) @(negedge clk);
    chk("R8 ready in reset", req_ready_o, 1);
    chk("R8 strobes in reset", {act_o, rd_o, pre_o, data_exp_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R8 ready after reset", req_ready_o, 1);
    // back-to-back: read counts 1..4 then 4 and 1
    for (int k = 0; k < 6; k++) run_txn(k);
    req_valid_i = 1'b0;
    while (cyc < next_a) @(negedge clk);
    for (int i = 0; i < 7; i++) begin
      drive_junk();
      chk("R7 ready while idle", req_ready_o, 1);
      @(negedge clk);
    end
    run_txn(6);
    req_valid_i = 1'b0;
    while (cyc < last_end) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog R6 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end
endmodule